// File: doc/BRIEF.md
# Mailbox Command Controller for a Cryptographic Coprocessor

This block is the control unit of a cryptographic coprocessor. The host talks to it only through a shared dual-port RAM. The host fills the RAM with data and then writes a command word at a fixed address. The controller polls that word. When it sees the valid bit, it takes the command, clears the valid bit in the RAM, and decodes one of three modes: encrypt, decrypt or self-test.

The controller then runs a fixed chain of engine calls. For each call it raises a one-cycle start pulse on one engine port and waits for that engine's done pulse. No two engines are ever busy at the same time. When the chain ends, the controller writes one status word into the RAM. The done bit of that word is the host's completion flag.

A message that does not fit in the RAM is sent as several chunks. Key setup runs only for the first chunk. Later chunks run only the data steps, and the signing step runs on the chunk marked last. Each engine call has a cycle budget. If an engine stalls, the controller reports a timeout instead of hanging.

Top module: `mbx_cmd_ctrl`

## Requirements
- R1: While bit 31 of the command word at RAM address 0 is 0, the controller starts no engine and writes nothing to the RAM.
- R2: On seeing bit 31 set, the controller writes the same word back to address 0 with only bit 31 cleared, before its first engine call.
- R3: The command word fields are: mode in bits [1:0] (01 encrypt, 10 decrypt, 11 self-test), role count in bits [7:4], last-chunk flag in bit 8. The engine numbering is 0 random key/IV, 1 ephemeral keys, 2 public keys, 3 key-encryption-key derivation, 4 key wrap, 5 data cipher, 6 packager, 7 signer. A first-chunk encrypt calls engines 0, 1, 2, then the pair 3, 4 once per role, then 5, 6, and 7 only if the chunk is last.
- R4: Each call is a single-cycle pulse on exactly one bit of `eng_start`. The next call is issued only after the current engine's done pulse has been seen.
- R5: A first-chunk decrypt calls engines 3, 4, 5, then 7 if last, with `eng_inv` high on every call. Its role count is ignored, and a single derive/unwrap pair is run.
- R6: Self-test ignores the role count and the last flag. It runs the full one-role encrypt chain including 7 with `eng_inv` low, then the decrypt chain 3, 4, 5, 7 with `eng_inv` high.
- R7: An encrypt or decrypt chunk with the last flag clear leaves the message open. The next encrypt/decrypt command skips setup: encrypt calls 5, 6; decrypt calls 5; both add 7 if last. A completed last chunk closes the message.
- R8: After each command the controller writes exactly one status word at address 1: bit 0 done, bit 1 error, bits [3:2] error code. A success writes 0x1.
- R9: Mode 00 makes no engine call, writes status 0x7 (code 1) and closes any open message.
- R10: A first-chunk encrypt with role count 0 makes no engine call and writes status 0xB (code 2). Continuation chunks do not check the role count.
- R11: If the awaited done is not seen within TIMEOUT_CYC cycles of waiting, the controller makes no further call, writes status 0xF (code 3) and closes the open message. A done pulse on the last allowed cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ram_en | output | 1 | RAM port access enable |
| ram_we | output | 1 | RAM port write enable |
| ram_addr | output | AW | RAM port word address |
| ram_wdata | output | DW | RAM port write data |
| ram_rdata | input | DW | RAM port read data, one cycle after a read |
| eng_start | output | 8 | One-cycle start pulse per engine |
| eng_done | input | 8 | Done pulse per engine |
| eng_inv | output | 1 | High when the current chain runs in the inverse (decrypt) direction |

## Verification
Two events can land in the same cycle: an engine's done pulse and the expiry of the wait budget. The bench gives the cipher engine a latency equal to TIMEOUT_CYC, so done arrives exactly on the final permitted wait cycle. It then repeats the run with one cycle more. The first run must finish the whole chain and report 0x1. The second must stop after the cipher call, report 0xF, and leave the message closed. Closure is judged by sending a continuation chunk with a zero role count, which must now be refused with code 2.

// File: rtl/mbx_ctrl_pkg.sv
package mbx_ctrl_pkg;

  localparam int unsigned NUM_ENG = 8;

  typedef enum logic [3:0] {
    STP_KEYGEN = 4'd0,
    STP_EPHEM  = 4'd1,
    STP_PUBKEY = 4'd2,
    STP_KDF    = 4'd3,
    STP_WRAP   = 4'd4,
    STP_CIPHER = 4'd5,
    STP_PACK   = 4'd6,
    STP_SIGN   = 4'd7,
    STP_END    = 4'd8
  } step_e;

  typedef enum logic [1:0] {
    MODE_NONE = 2'b00,
    MODE_ENC  = 2'b01,
    MODE_DEC  = 2'b10,
    MODE_TEST = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_MODE    = 2'd1,
    ERR_ROLES   = 2'd2,
    ERR_TIMEOUT = 2'd3
  } err_e;

  typedef enum logic [2:0] {
    S_POLL, S_CHK, S_CLR, S_DEC, S_CALL, S_WAIT, S_NEXT, S_STAT
  } fsm_e;

endpackage

// File: rtl/mbx_rst_sync.sv
module mbx_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/mbx_cmd_decode.sv
module mbx_cmd_decode
  import mbx_ctrl_pkg::*;
#(
  parameter int unsigned DW       = 32,
  parameter int unsigned ROLE_W   = 4,
  parameter int unsigned ROLE_LSB = 4,
  parameter int unsigned LAST_BIT = 8
) (
  input  logic [DW-1:0]     word,
  input  logic              msg_open,
  output mode_e             mode,
  output logic [ROLE_W-1:0] roles,
  output logic              last,
  output logic              setup,
  output err_e              err
);
  logic unused_bits;

  assign mode  = mode_e'(word[1:0]);
  assign roles = word[ROLE_LSB +: ROLE_W];
  assign last  = word[LAST_BIT];
  assign unused_bits = ^word;

  // Self-test always runs the full chain; others skip setup when continuing.
  assign setup = !msg_open || (mode == MODE_TEST);

  always_comb begin
    err = ERR_NONE;
    if (mode == MODE_NONE)                                    err = ERR_MODE;
    else if ((mode == MODE_ENC) && setup && (roles == '0))    err = ERR_ROLES;
  end
endmodule

// File: rtl/mbx_step_seq.sv
module mbx_step_seq
  import mbx_ctrl_pkg::*;
#(
  parameter int unsigned ROLE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              adv,
  input  mode_e             ld_mode,
  input  logic [ROLE_W-1:0] ld_roles,
  input  logic              ld_last,
  input  logic              ld_setup,
  output step_e             step,
  output logic              inv
);
  step_e             step_q, step_d;
  logic              dec_q, dec_d;
  logic              test_q, test_d;
  logic              last_q, last_d;
  logic [ROLE_W-1:0] roles_q, roles_d;
  logic              seq_en;

  assign seq_en = load || adv;

  always_comb begin
    step_d  = step_q;
    dec_d   = dec_q;
    test_d  = test_q;
    last_d  = last_q;
    roles_d = roles_q;
    if (load) begin
      dec_d   = (ld_mode == MODE_DEC);
      test_d  = (ld_mode == MODE_TEST);
      last_d  = ld_last || (ld_mode == MODE_TEST);
      roles_d = (ld_mode == MODE_ENC) ? ld_roles : ROLE_W'(1);
      if (!ld_setup)                   step_d = STP_CIPHER;
      else if (ld_mode == MODE_DEC)    step_d = STP_KDF;
      else                             step_d = STP_KEYGEN;
    end else if (adv) begin
      unique case (step_q)
        STP_KEYGEN: step_d = STP_EPHEM;
        STP_EPHEM:  step_d = STP_PUBKEY;
        STP_PUBKEY: step_d = STP_KDF;
        STP_KDF:    step_d = STP_WRAP;
        STP_WRAP: begin
          roles_d = roles_q - ROLE_W'(1);
          step_d  = (roles_q > ROLE_W'(1)) ? STP_KDF : STP_CIPHER;
        end
        STP_CIPHER: step_d = dec_q ? (last_q ? STP_SIGN : STP_END) : STP_PACK;
        STP_PACK:   step_d = last_q ? STP_SIGN : STP_END;
        STP_SIGN:   step_d = STP_END;
        default:    step_d = STP_END;
      endcase
      // Self-test: the forward chain is followed by the inverse chain.
      if (test_q && !dec_q && (step_d == STP_END)) begin
        dec_d   = 1'b1;
        roles_d = ROLE_W'(1);
        step_d  = STP_KDF;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q  <= STP_END;
      dec_q   <= 1'b0;
      test_q  <= 1'b0;
      last_q  <= 1'b0;
      roles_q <= '0;
    end else if (seq_en) begin
      step_q  <= step_d;
      dec_q   <= dec_d;
      test_q  <= test_d;
      last_q  <= last_d;
      roles_q <= roles_d;
    end
  end

  assign step = step_q;
  assign inv  = dec_q;

  AST_WRAP_HAS_ROLE: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == STP_WRAP) |-> (roles_q != '0)); // R3
  AST_SIGN_ONLY_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (step_q == STP_SIGN) |-> last_q); // R7
endmodule

// File: rtl/mbx_wait_timer.sv
module mbx_wait_timer #(
  parameter int unsigned LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic done,
  output logic expired
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = run || (cnt_q != '0);
  assign cnt_d  = run ? (cnt_q + CW'(1)) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // Done wins when it arrives on the final allowed cycle.
  assign expired = run && !done && (cnt_q == CW'(LIMIT - 1));

  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < CW'(LIMIT))); // R11
endmodule

// File: rtl/mbx_cmd_ctrl.sv
module mbx_cmd_ctrl
  import mbx_ctrl_pkg::*;
#(
  parameter int unsigned DW          = 32,
  parameter int unsigned AW          = 4,
  parameter int unsigned CMD_ADDR    = 0,
  parameter int unsigned STAT_ADDR   = 1,
  parameter int unsigned ROLE_W      = 4,
  parameter int unsigned TIMEOUT_CYC = 1024
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic               ram_en,
  output logic               ram_we,
  output logic [AW-1:0]      ram_addr,
  output logic [DW-1:0]      ram_wdata,
  input  logic [DW-1:0]      ram_rdata,
  output logic [NUM_ENG-1:0] eng_start,
  input  logic [NUM_ENG-1:0] eng_done,
  output logic               eng_inv
);
  localparam int unsigned VALID_BIT = DW - 1;
  localparam logic [AW-1:0] CMD_A  = AW'(CMD_ADDR);
  localparam logic [AW-1:0] STAT_A = AW'(STAT_ADDR);
  localparam logic [DW-1:0] VALID_MASK = {1'b1, {(DW-1){1'b0}}};

  logic rst_s;

  fsm_e              state_q, state_d;
  logic [DW-1:0]     cmd_q;
  logic              cmd_en;
  err_e              err_q, err_d;
  logic              err_en;
  logic              open_q, open_d, open_en;
  logic              seq_load, seq_adv;
  mode_e             dec_mode;
  logic [ROLE_W-1:0] dec_roles;
  logic              dec_last, dec_setup;
  err_e              dec_err;
  step_e             seq_step;
  logic [NUM_ENG-1:0] step_oh;
  logic              wait_run, tmo;

  mbx_rst_sync u_rst (.clk(clk), .rst_ni(rst_n), .rst_no(rst_s));

  mbx_cmd_decode #(.DW(DW), .ROLE_W(ROLE_W)) u_dec (
    .word(cmd_q), .msg_open(open_q), .mode(dec_mode), .roles(dec_roles),
    .last(dec_last), .setup(dec_setup), .err(dec_err)
  );

  mbx_step_seq #(.ROLE_W(ROLE_W)) u_seq (
    .clk(clk), .rst_n(rst_s), .load(seq_load), .adv(seq_adv),
    .ld_mode(dec_mode), .ld_roles(dec_roles), .ld_last(dec_last),
    .ld_setup(dec_setup), .step(seq_step), .inv(eng_inv)
  );

  assign step_oh  = NUM_ENG'(1) << seq_step;
  assign wait_run = (state_q == S_WAIT);

  mbx_wait_timer #(.LIMIT(TIMEOUT_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_s), .run(wait_run),
    .done(|(eng_done & step_oh)), .expired(tmo)
  );

  always_comb begin
    state_d   = state_q;
    cmd_en    = 1'b0;
    err_en    = 1'b0;
    err_d     = err_q;
    open_en   = 1'b0;
    open_d    = open_q;
    seq_load  = 1'b0;
    seq_adv   = 1'b0;
    ram_en    = 1'b0;
    ram_we    = 1'b0;
    ram_addr  = CMD_A;
    ram_wdata = '0;
    eng_start = '0;
    unique case (state_q)
      S_POLL: begin
        ram_en  = 1'b1;
        state_d = S_CHK;
      end
      S_CHK: begin
        if (ram_rdata[VALID_BIT]) begin
          cmd_en  = 1'b1;
          state_d = S_CLR;
        end else begin
          state_d = S_POLL;
        end
      end
      S_CLR: begin
        ram_en    = 1'b1;
        ram_we    = 1'b1;
        ram_wdata = cmd_q & ~VALID_MASK;
        state_d   = S_DEC;
      end
      S_DEC: begin
        err_en = 1'b1;
        err_d  = dec_err;
        if (dec_err != ERR_NONE) begin
          open_en = 1'b1;
          open_d  = 1'b0;
          state_d = S_STAT;
        end else begin
          seq_load = 1'b1;
          state_d  = S_CALL;
        end
      end
      S_CALL: begin
        eng_start = step_oh;
        state_d   = S_WAIT;
      end
      S_WAIT: begin
        if (|(eng_done & step_oh)) begin
          seq_adv = 1'b1;
          state_d = S_NEXT;
        end else if (tmo) begin
          err_en  = 1'b1;
          err_d   = ERR_TIMEOUT;
          open_en = 1'b1;
          open_d  = 1'b0;
          state_d = S_STAT;
        end
      end
      S_NEXT: begin
        if (seq_step == STP_END) begin
          if (dec_mode != MODE_TEST) begin
            open_en = 1'b1;
            open_d  = !dec_last;
          end
          state_d = S_STAT;
        end else begin
          state_d = S_CALL;
        end
      end
      S_STAT: begin
        ram_en    = 1'b1;
        ram_we    = 1'b1;
        ram_addr  = STAT_A;
        ram_wdata = DW'({err_q, (err_q != ERR_NONE), 1'b1});
        state_d   = S_POLL;
      end
      default: state_d = S_POLL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) state_q <= S_POLL;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)      cmd_q <= '0;
    else if (cmd_en) cmd_q <= ram_rdata;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)      err_q <= ERR_NONE;
    else if (err_en) err_q <= err_d;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)       open_q <= 1'b0;
    else if (open_en) open_q <= open_d;
  end

  AST_START_ONEHOT: assert property (@(posedge clk) disable iff (!rst_s)
    $onehot0(eng_start)); // R4
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_s)
    (eng_start != '0) |=> (eng_start == '0)); // R4
  AST_INV_HELD: assert property (@(posedge clk) disable iff (!rst_s)
    (eng_start != '0) |=> $stable(eng_inv)); // R5
  AST_WRITE_TARGET: assert property (@(posedge clk) disable iff (!rst_s)
    (ram_en && ram_we) |-> ((ram_addr == CMD_A) || (ram_addr == STAT_A))); // R8
  AST_NO_CALL_IDLE: assert property (@(posedge clk) disable iff (!rst_s)
    (state_q == S_CHK && !ram_rdata[VALID_BIT]) |=> (eng_start == '0)); // R1
endmodule

// File: tb/mbx_cmd_ctrl_tb.sv
module mbx_cmd_ctrl_tb;
  localparam int TO   = 20;
  localparam int CMDA = 0;
  localparam int STA  = 1;

  logic        clk, rst_n;
  logic        ram_en, ram_we;
  logic [3:0]  ram_addr;
  logic [31:0] ram_wdata, ram_rdata;
  logic [7:0]  eng_start, eng_done;
  logic        eng_inv;

  logic [31:0] mem [16];
  int          ecnt [8];
  int          lat [8];
  logic [3:0]  log_e [32];
  logic        log_inv [32];
  int ncalls, nwr, nstat, nchk, nerr;

  mbx_cmd_ctrl #(.TIMEOUT_CYC(TO)) u_dut (
    .clk(clk), .rst_n(rst_n), .ram_en(ram_en), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
    .eng_start(eng_start), .eng_done(eng_done), .eng_inv(eng_inv)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Shared RAM, controller side
  always @(posedge clk) begin
    if (ram_en && ram_we) begin
      mem[ram_addr] = ram_wdata;
      nwr++;
      if (ram_addr == 4'(STA)) nstat++;
    end
    if (ram_en && !ram_we) ram_rdata <= mem[ram_addr];
  end

  // Engine models and call log
  always @(posedge clk) begin
    for (int i = 0; i < 8; i++) begin
      if (eng_start[i]) ecnt[i] <= lat[i];
      else if (ecnt[i] != 0) ecnt[i] <= ecnt[i] - 1;
      if (rst_n && eng_start[i] && ncalls < 32) begin
        log_e[ncalls]   = 4'(i);
        log_inv[ncalls] = eng_inv;
        ncalls++;
      end
    end
  end

  always_comb
    for (int i = 0; i < 8; i++) eng_done[i] = (ecnt[i] == 1);

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] w, input logic [63:0] eseq, input int en,
                       input logic [15:0] einv, input logic [31:0] estat, input string req);
    logic [63:0] aseq;
    logic [15:0] ainv;
    int k;
    @(negedge clk);
    ncalls = 0; nstat = 0;
    mem[STA] = 32'h0;
    mem[CMDA] = w;
    k = 0;
    while (!mem[STA][0] && k < 3000) begin @(negedge clk); k++; end
    repeat (4) @(negedge clk);
    aseq = '0; ainv = '0;
    for (int i = 0; i < ncalls && i < 16; i++) begin
      aseq[i*4 +: 4] = log_e[i];
      ainv[i]        = log_inv[i];
    end
    chk(mem[STA] == estat, req, "status word", 64'(mem[STA]), 64'(estat));
    chk(nstat == 1, "R8", "status write count", 64'(nstat), 64'd1);
    chk(ncalls == en, req, "engine call count", 64'(ncalls), 64'(en));
    chk(aseq == eseq, req, "engine call order", aseq, eseq);
    chk(ainv == einv, req, "inverse flag per call", 64'(ainv), 64'(einv));
    chk(mem[CMDA] == (w & 32'h7fff_ffff), "R2", "command valid bit cleared",
        64'(mem[CMDA]), 64'(w & 32'h7fff_ffff));
  endtask

  task automatic t_reset;
    chk(eng_start == 8'h0 && ram_we == 1'b0, "R1", "quiet in reset",
        64'({eng_start, ram_we}), 64'h0);
  endtask

  task automatic t_idle;  // R1
    @(negedge clk);
    ncalls = 0; nwr = 0;
    mem[STA] = 32'hDEAD;
    mem[CMDA] = 32'h0000_0121;
    repeat (40) @(negedge clk);
    chk(ncalls == 0, "R1", "no call while invalid", 64'(ncalls), 64'd0);
    chk(nwr == 0, "R1", "no RAM write while invalid", 64'(nwr), 64'd0);
    chk(mem[CMDA] == 32'h121 && mem[STA] == 32'hDEAD, "R1", "mailbox untouched",
        64'({mem[CMDA], mem[STA]}), 64'h0000_0121_0000_DEAD);
  endtask

  task automatic t_encrypt;  // R3
    issue(32'h8000_0121, 64'h76_5434_3210, 10, 16'h0, 32'h1, "R3");
  endtask

  task automatic t_decrypt;  // R5
    issue(32'h8000_0102, 64'h7543, 4, 16'hF, 32'h1, "R5");
  endtask

  task automatic t_selftest;  // R6
    issue(32'h8000_0003, 64'h7543_7654_3210, 12, 16'h0F00, 32'h1, "R6");
  endtask

  task automatic t_chunks;  // R7
    issue(32'h8000_0011, 64'h654_3210, 7, 16'h0, 32'h1, "R7");
    issue(32'h8000_0001, 64'h65, 2, 16'h0, 32'h1, "R7");
    issue(32'h8000_0101, 64'h765, 3, 16'h0, 32'h1, "R7");
    issue(32'h8000_0002, 64'h543, 3, 16'h7, 32'h1, "R7");
    issue(32'h8000_0102, 64'h75, 2, 16'h3, 32'h1, "R7");
  endtask

  task automatic t_errors;  // R9 R10
    issue(32'h8000_0101, 64'h0, 0, 16'h0, 32'hB, "R10");
    issue(32'h8000_0011, 64'h654_3210, 7, 16'h0, 32'h1, "R7");
    issue(32'h8000_0140, 64'h0, 0, 16'h0, 32'h7, "R9");
    issue(32'h8000_0111, 64'h7654_3210, 8, 16'h0, 32'h1, "R9");
  endtask

  task automatic t_timeout;  // R11
    lat[5] = TO;
    issue(32'h8000_0111, 64'h7654_3210, 8, 16'h0, 32'h1, "R11");
    lat[5] = TO + 1;
    issue(32'h8000_0011, 64'h54_3210, 6, 16'h0, 32'hF, "R11");
    lat[5] = 3;
    repeat (30) @(negedge clk);
    issue(32'h8000_0101, 64'h0, 0, 16'h0, 32'hB, "R11");
    lat[0] = 1; lat[4] = 1; lat[7] = 5;
    issue(32'h8000_0111, 64'h7654_3210, 8, 16'h0, 32'h1, "R4");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    nchk = 0; nerr = 0; ncalls = 0; nwr = 0; nstat = 0;
    ram_rdata = 32'h0;
    for (int i = 0; i < 16; i++) mem[i] = 32'h0;
    for (int i = 0; i < 8; i++) begin lat[i] = 3; ecnt[i] = 0; end
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_idle;
    t_encrypt;
    t_decrypt;
    t_selftest;
    t_chunks;
    t_errors;
    t_timeout;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule